// File: doc/BRIEF.md
# Wiper Position Register with Tap Decode

This block holds the 8-bit volatile position of a digitally controlled potentiometer wiper and turns it into a one-hot select for the 256 tap switches of the resistor string. Position 0 connects the wiper to the low terminal and position 255 connects it to the high terminal. The position can change in four ways:

- a one-time recall of the default stored value after power-up;
- a direct write of a byte from the host;
- a parallel transfer of a byte read from a stored data register;
- single steps toward either terminal.

The tap select does not follow the register at once. A change reaches the tap switches only after a settling window of `SETTLE_CYC` clock cycles, counted from the last write. An applied flag reports whether the switches already show the register value.

The two byte sources are valid/ready streams. A byte moves on a cycle where both valid and ready are high. Before the recall has happened, both readies are low, so a sender holds its byte until then. A direct write has priority over a transfer. While a direct write is valid, the transfer ready stays low, and a transfer sender must keep its valid and data stable until it is accepted. The step, recall and status pins are plain signals.

Top module: `wiper_position_unit`

## Requirements
- R1: While reset is asserted, wiper_val is 0, tap_sel has only bit 0 set, applied is 1, and both dw_ready and xf_ready are 0.
- R2: The first cycle with recall_req high after reset loads recall_data into wiper_val on the next edge. Every later recall_req is ignored.
- R3: Until the recall has happened, dw_ready and xf_ready are 0, and step_up and step_dn leave wiper_val unchanged.
- R4: After the recall, dw_ready is 1. A cycle with dw_valid high loads dw_data into wiper_val on the next edge.
- R5: xf_ready is 1 after the recall only while dw_valid is 0. A cycle with xf_valid and xf_ready both high loads xf_data into wiper_val on the next edge.
- R6: A cycle with step_up high and step_dn low adds 1 to wiper_val, holding at 255. A cycle with step_dn high and step_up low subtracts 1, holding at 0. Both high together changes nothing.
- R7: A step in the same cycle as an accepted byte is dropped, and the accepted byte sets wiper_val.
- R8: tap_sel always has exactly one bit set. Bit i selects tap i, where tap 0 is the low terminal and tap 255 is the high terminal.
- R9: tap_sel takes the value of wiper_val exactly SETTLE_CYC edges after the last write, counting recalls, byte loads and steps (saturated steps included). Each write restarts the count.
- R10: applied is 1 exactly when the tap selected by tap_sel equals wiper_val.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recall_req | input | 1 | Power-up recall strobe |
| recall_data | input | 8 | Default position for recall |
| dw_valid | input | 1 | Direct write byte valid |
| dw_ready | output | 1 | Direct write byte accepted |
| dw_data | input | 8 | Direct write byte |
| xf_valid | input | 1 | Transfer byte valid |
| xf_ready | output | 1 | Transfer byte accepted |
| xf_data | input | 8 | Transfer byte from a stored register |
| step_up | input | 1 | Step one tap toward the high terminal |
| step_dn | input | 1 | Step one tap toward the low terminal |
| wiper_val | output | 8 | Current register value |
| tap_sel | output | 256 | One-hot tap switch select |
| applied | output | 1 | Tap select matches the register |

## Verification
The bench builds the block with an 8-bit position and SETTLE_CYC of 4. This short window lets writes spaced two cycles apart keep restarting the settling count, so the delayed update of tap_sel and the low phases of applied can be seen within a few cycles. The 8-bit width keeps both saturation ends, 0 and 255, in reach through the recall and direct write values. The default window of 500 cycles is a plain counter limit and is only elaborated.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_RECALL,
    SRC_DIRECT,
    SRC_XFER,
    SRC_UP,
    SRC_DOWN
  } wsrc_e;
endpackage

// File: rtl/wiper_arbiter.sv
module wiper_arbiter
  import wiper_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         recalled,
  input  logic         recall_req,
  input  logic [W-1:0] recall_data,
  input  logic         dw_valid,
  input  logic [W-1:0] dw_data,
  input  logic         xf_valid,
  input  logic [W-1:0] xf_data,
  input  logic         step_up,
  input  logic         step_dn,
  input  logic [W-1:0] cur,
  output logic         dw_ready,
  output logic         xf_ready,
  output wsrc_e        src,
  output logic         wr_en,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] BOT = '0;

  assign dw_ready = recalled;
  assign xf_ready = recalled && !dw_valid;

  always_comb begin
    src = SRC_NONE;
    if (!recalled) begin
      if (recall_req) src = SRC_RECALL;
    end else if (dw_valid) begin
      src = SRC_DIRECT;
    end else if (xf_valid) begin
      src = SRC_XFER;
    end else if (step_up && !step_dn) begin
      src = SRC_UP;
    end else if (step_dn && !step_up) begin
      src = SRC_DOWN;
    end
  end

  always_comb begin
    wr_en = 1'b1;
    nxt   = cur;
    unique case (src)
      SRC_RECALL: nxt = recall_data;
      SRC_DIRECT: nxt = dw_data;
      SRC_XFER:   nxt = xf_data;
      SRC_UP:     nxt = (cur == TOP) ? cur : cur + 1'b1;
      SRC_DOWN:   nxt = (cur == BOT) ? cur : cur - 1'b1;
      default:    wr_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/wiper_settle.sv
module wiper_settle #(
  parameter int W          = 8,
  parameter int SETTLE_CYC = 500
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wiper_q,
  output logic [W-1:0] shown_q
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      shown_q <= '0;
    end else if (wr_en) begin
      cnt_q <= LOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) shown_q <= wiper_q;
    end
  end

  // R9: the tap position moves only when the settling count expires
  p_hold_until_expiry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q > CW'(1)) |=> $stable(shown_q));
endmodule

// File: rtl/wiper_decode.sv
module wiper_decode #(
  parameter int W = 8
) (
  input  logic [W-1:0]      pos,
  output logic [2**W-1:0]   sel
);
  localparam int N = 2 ** W;

  for (genvar i = 0; i < N; i++) begin : g_tap
    assign sel[i] = (pos == W'(i));
  end
endmodule

// File: rtl/wiper_position_unit.sv
module wiper_position_unit
  import wiper_pkg::*;
#(
  parameter int W          = 8,
  parameter int SETTLE_CYC = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              recall_req,
  input  logic [W-1:0]      recall_data,
  input  logic              dw_valid,
  output logic              dw_ready,
  input  logic [W-1:0]      dw_data,
  input  logic              xf_valid,
  output logic              xf_ready,
  input  logic [W-1:0]      xf_data,
  input  logic              step_up,
  input  logic              step_dn,
  output logic [W-1:0]      wiper_val,
  output logic [2**W-1:0]   tap_sel,
  output logic              applied
);
  localparam int N = 2 ** W;
  localparam logic [W-1:0] TOP = '1;

  logic         recalled_q;
  logic [W-1:0] wiper_q;
  logic [W-1:0] shown;
  logic [W-1:0] nxt;
  logic         wr_en;
  wsrc_e        src;

  wiper_arbiter #(.W(W)) u_arb (
    .recalled   (recalled_q),
    .recall_req (recall_req),
    .recall_data(recall_data),
    .dw_valid   (dw_valid),
    .dw_data    (dw_data),
    .xf_valid   (xf_valid),
    .xf_data    (xf_data),
    .step_up    (step_up),
    .step_dn    (step_dn),
    .cur        (wiper_q),
    .dw_ready   (dw_ready),
    .xf_ready   (xf_ready),
    .src        (src),
    .wr_en      (wr_en),
    .nxt        (nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper_q    <= '0;
      recalled_q <= 1'b0;
    end else begin
      if (wr_en) wiper_q <= nxt;
      if (src == SRC_RECALL) recalled_q <= 1'b1;
    end
  end

  wiper_settle #(.W(W), .SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wiper_q(wiper_q),
    .shown_q(shown)
  );

  wiper_decode #(.W(W)) u_dec (
    .pos(shown),
    .sel(tap_sel)
  );

  assign wiper_val = wiper_q;
  assign applied   = (shown == wiper_q);

  // R8: one tap switch closed at all times
  p_one_tap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel) == 1);

  // R3: nothing moves the register before the recall
  p_idle_before_recall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!dw_ready && !recall_req) |=> $stable(wiper_val));

  // R4: an accepted direct byte lands in the register
  p_direct_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dw_valid && dw_ready) |=> (wiper_val == $past(dw_data)));

  // R5: an accepted transfer byte lands in the register
  p_xfer_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xf_valid && xf_ready) |=> (wiper_val == $past(xf_data)));

  // R6: stepping up at the top end holds the value
  p_sat_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dw_ready && !dw_valid && !xf_valid && step_up && !step_dn &&
     wiper_val == TOP) |=> (wiper_val == TOP));

  // R10: applied agrees with the closed tap
  p_applied_r10: assert property (@(posedge clk) disable iff (!rst_n)
    applied == tap_sel[wiper_val]);

  if (N < 2) begin : g_bad_width
    initial $error("wiper_position_unit needs W >= 1");
  end
endmodule

// File: tb/sim_wiper_position_unit.sv
`timescale 1ns/1ps
module sim_wiper_position_unit;
  localparam int W  = 8;
  localparam int N  = 2 ** W;
  localparam int SC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic recall_req = 1'b0;
  logic [W-1:0] recall_data = '0;
  logic dw_valid = 1'b0;
  logic dw_ready;
  logic [W-1:0] dw_data = '0;
  logic xf_valid = 1'b0;
  logic xf_ready;
  logic [W-1:0] xf_data = '0;
  logic step_up = 1'b0;
  logic step_dn = 1'b0;
  logic [W-1:0] wiper_val;
  logic [N-1:0] tap_sel;
  logic applied;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string cur_req = "R1";

  int m_wiper, m_shown, m_wait;
  bit m_done;

  always #10 clk = ~clk;

  wiper_position_unit #(.W(W), .SETTLE_CYC(SC)) u0 (
    .clk(clk), .rst_n(rst_n),
    .recall_req(recall_req), .recall_data(recall_data),
    .dw_valid(dw_valid), .dw_ready(dw_ready), .dw_data(dw_data),
    .xf_valid(xf_valid), .xf_ready(xf_ready), .xf_data(xf_data),
    .step_up(step_up), .step_dn(step_dn),
    .wiper_val(wiper_val), .tap_sel(tap_sel), .applied(applied)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // compare every cycle, then advance the reference model
  always @(negedge clk) begin
    #1;
    if (!rst_n) begin
      m_wiper = 0; m_shown = 0; m_wait = 0; m_done = 0;
    end
    begin
      logic [N-1:0] exp_sel;
      exp_sel = '0;
      exp_sel[m_shown] = 1'b1;
      chk(wiper_val == m_wiper[W-1:0], cur_req, "wiper_val", wiper_val, m_wiper);
      chk(tap_sel == exp_sel, "R8/R9", "tap index", $clog2(tap_sel + 1) - 1, m_shown);
      chk(applied == (m_shown == m_wiper), "R10", "applied", applied, m_shown == m_wiper);
      chk(dw_ready == m_done, cur_req, "dw_ready", dw_ready, m_done);
      chk(xf_ready == (m_done && !dw_valid), cur_req, "xf_ready", xf_ready, m_done && !dw_valid);
    end
    if (rst_n) begin
      bit wr;
      int nw;
      wr = 0;
      nw = m_wiper;
      if (!m_done) begin
        if (recall_req) begin nw = recall_data; wr = 1; m_done = 1; end
      end else if (dw_valid) begin
        nw = dw_data; wr = 1;
      end else if (xf_valid) begin
        nw = xf_data; wr = 1;
      end else if (step_up && !step_dn) begin
        nw = (m_wiper == N - 1) ? m_wiper : m_wiper + 1; wr = 1;
      end else if (step_dn && !step_up) begin
        nw = (m_wiper == 0) ? 0 : m_wiper - 1; wr = 1;
      end
      if (wr) m_wait = SC;
      else if (m_wait > 0) begin
        if (m_wait == 1) m_shown = m_wiper;
        m_wait--;
      end
      m_wiper = nw;
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    tick(3);
    rst_n = 1'b1;
    // R3: activity before the recall
    cur_req = "R3";
    step_up = 1; dw_valid = 1; dw_data = 8'h77; xf_valid = 1; xf_data = 8'h66;
    tick(2);
    step_up = 0; dw_valid = 0; xf_valid = 0; step_dn = 1;
    tick(2);
    step_dn = 0;
    tick();
    // R2: recall loads the default position
    cur_req = "R2";
    recall_req = 1; recall_data = 8'hFE;
    tick();
    recall_req = 0;
    tick(6);
    // R6: saturate at the top
    cur_req = "R6";
    step_up = 1;
    tick(3);
    step_up = 0;
    tick(6);
    // R4: direct write
    cur_req = "R4";
    dw_valid = 1; dw_data = 8'h01;
    tick();
    dw_valid = 0;
    tick(6);
    // R6: saturate at the bottom, then both steps together
    cur_req = "R6";
    step_dn = 1;
    tick(3);
    step_dn = 0;
    tick(6);
    dw_valid = 1; dw_data = 8'h40;
    tick();
    dw_valid = 0; step_up = 1; step_dn = 1;
    tick(2);
    step_up = 0; step_dn = 0;
    tick(6);
    // R5: direct has priority, transfer waits
    cur_req = "R5";
    dw_valid = 1; dw_data = 8'h3C; xf_valid = 1; xf_data = 8'hA5;
    tick();
    dw_valid = 0;
    tick();
    xf_valid = 0;
    tick(6);
    xf_valid = 1; xf_data = 8'h5A;
    tick();
    xf_valid = 0;
    tick(6);
    // R7: steps dropped under a byte load
    cur_req = "R7";
    dw_valid = 1; dw_data = 8'h80; step_up = 1;
    tick();
    dw_valid = 0; step_up = 0; xf_valid = 1; xf_data = 8'h20; step_dn = 1;
    tick();
    xf_valid = 0; step_dn = 0;
    tick(6);
    // R2: a second recall is ignored
    cur_req = "R2";
    recall_req = 1; recall_data = 8'h11;
    tick(2);
    recall_req = 0;
    tick(6);
    // R9: writes closer than the settling window keep restarting it
    cur_req = "R9";
    for (int k = 1; k <= 4; k++) begin
      dw_valid = 1; dw_data = 8'(k * 16);
      tick();
      dw_valid = 0;
      tick();
    end
    tick(8);
    // R10: a single step shows applied low for the window
    cur_req = "R10";
    step_up = 1;
    tick();
    step_up = 0;
    tick(8);
    finished = 1;
    summary();
    $finish;
  end
endmodule